// File: doc/BRIEF.md
# Dual 8-bit GPIO Port Controller with Grouped Pad Configuration

This block gives software control of two 8-bit bidirectional ports, called A and B, through a simple single-cycle register bus. Each pin has a port latch and a direction bit. A set direction bit turns the pin's output driver on, and the driver carries the latch value. A read of a port's data address returns a mix of two sources. Output pins return their latch bit. Input pins return the external level after a two-flop synchronizer.

Three shared configuration registers set pad behaviour. In the pull-up and drive registers, one bit covers a group of pins, and the groups are uneven in size. The input-threshold register uses only three bits. A pull-up is always cut off while its pin is an output. The block produces only the logical pad controls. Actual pad strengths and voltage thresholds belong to the pad ring.

Top module: `gpio_dual_port_ctl`

## Requirements
- R1: After reset, every register reads 0x00 and every output is 0: `oe_*`, `dout_*`, `pu_*`, `drv_*` and `ttl_*`.
- R2: The register map is: 0x00 port A data, 0x01 port A direction, 0x02 port B data, 0x03 port B direction, 0x15 drive select, 0x16 pull-up select, 0x17 input-level select. `oe_a`/`oe_b` equal the direction bits (1 = output) and `dout_a`/`dout_b` equal the latches.
- R3: A data read returns the latch bit where the direction bit is 1 and the synchronized pin bit where it is 0.
- R4: A change on an input pin is not visible in a data read after one rising edge. It is visible after the second rising edge.
- R5: A write to a data address while pins are inputs updates only the latch, and `oe` stays 0. Setting the direction bit later drives the stored value.
- R6: A write to a direction address leaves the latch, and so `dout`, unchanged on the next cycle.
- R7: Pull-up group mapping, with 1 = on. Bit0 covers A0, bit1 covers A1–A2, bit2 covers A3–A7, bit3 covers B0, bit4 covers B1–B2, bit5 covers B3, bit6 covers B4–B5 and bit7 covers B6–B7.
- R8: A pin's `pu` output is its group bit ANDed with the inverse of its direction bit. It is never 1 while `oe` is 1.
- R9: `drv_a`/`drv_b` use the same group mapping as R7, with 1 = high drive. They do not depend on direction.
- R10: Input-level register: bit0 sets TTL on B7, bit1 sets TTL on B6, and bit2 sets TTL on A0, A2 and A3 together (1 = TTL, 0 = CMOS). All other `ttl` bits stay 0, and register bits 7:3 read 0.
- R11: A read of any unmapped address returns 0x00, and a write to one changes no register or output.
- R12: The drive and pull-up registers read back the full written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pin_in_a | input | 8 | External levels, port A |
| pin_in_b | input | 8 | External levels, port B |
| oe_a | output | 8 | Output enables, port A |
| oe_b | output | 8 | Output enables, port B |
| dout_a | output | 8 | Output data, port A |
| dout_b | output | 8 | Output data, port B |
| pu_a | output | 8 | Pull-up enables, port A |
| pu_b | output | 8 | Pull-up enables, port B |
| drv_a | output | 8 | High-drive selects, port A |
| drv_b | output | 8 | High-drive selects, port B |
| ttl_a | output | 8 | TTL threshold selects, port A |
| ttl_b | output | 8 | TTL threshold selects, port B |

## Verification
All state in this block is visible at its ports. A corrupted latch or direction bit shows on `dout`/`oe` and in the data read on the cycle after the write. A wrong group decode shows on `pu`/`drv` right away. The bench writes single-group patterns so that each misrouted bit lands on a pin it can tell apart from the others. The synchronizer depth is checked at the exact edge where an input change becomes readable. A missing or extra stage shifts that edge by one cycle.

// File: rtl/gpio_dual_port_ctl.sv
module gpio_dual_port_ctl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_DATA_A = 'h00,
  parameter logic [AW-1:0] ADDR_DIR_A  = 'h01,
  parameter logic [AW-1:0] ADDR_DATA_B = 'h02,
  parameter logic [AW-1:0] ADDR_DIR_B  = 'h03,
  parameter logic [AW-1:0] ADDR_DRV    = 'h15,
  parameter logic [AW-1:0] ADDR_PULL   = 'h16,
  parameter logic [AW-1:0] ADDR_LVL    = 'h17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    pin_in_a,
  input  logic [7:0]    pin_in_b,
  output logic [7:0]    oe_a,
  output logic [7:0]    oe_b,
  output logic [7:0]    dout_a,
  output logic [7:0]    dout_b,
  output logic [7:0]    pu_a,
  output logic [7:0]    pu_b,
  output logic [7:0]    drv_a,
  output logic [7:0]    drv_b,
  output logic [7:0]    ttl_a,
  output logic [7:0]    ttl_b
);

  logic [7:0] lat_a, lat_b, dir_a, dir_b, drv_q, pull_q;
  logic [2:0] lvl_q;
  logic [7:0] s1_a, s2_a, s1_b, s2_b;

  wire wr = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0; lat_b <= '0; dir_a <= '0; dir_b <= '0;
      drv_q <= '0; pull_q <= '0; lvl_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        ADDR_DATA_A: lat_a  <= bus_wdata;
        ADDR_DIR_A:  dir_a  <= bus_wdata;
        ADDR_DATA_B: lat_b  <= bus_wdata;
        ADDR_DIR_B:  dir_b  <= bus_wdata;
        ADDR_DRV:    drv_q  <= bus_wdata;
        ADDR_PULL:   pull_q <= bus_wdata;
        ADDR_LVL:    lvl_q  <= bus_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a <= '0; s2_a <= '0; s1_b <= '0; s2_b <= '0;
    end else begin
      s1_a <= pin_in_a; s2_a <= s1_a;
      s1_b <= pin_in_b; s2_b <= s1_b;
    end
  end

  function automatic logic [7:0] grp_a(input logic [7:0] g);
    return {{5{g[2]}}, {2{g[1]}}, g[0]};
  endfunction

  function automatic logic [7:0] grp_b(input logic [7:0] g);
    return {{2{g[7]}}, {2{g[6]}}, g[5], {2{g[4]}}, g[3]};
  endfunction

  assign oe_a   = dir_a;
  assign oe_b   = dir_b;
  assign dout_a = lat_a;
  assign dout_b = lat_b;
  assign pu_a   = grp_a(pull_q) & ~dir_a;
  assign pu_b   = grp_b(pull_q) & ~dir_b;
  assign drv_a  = grp_a(drv_q);
  assign drv_b  = grp_b(drv_q);
  assign ttl_a  = {4'b0, lvl_q[2], lvl_q[2], 1'b0, lvl_q[2]};
  assign ttl_b  = {lvl_q[0], lvl_q[1], 6'b0};

  always_comb begin
    case (bus_addr)
      ADDR_DATA_A: bus_rdata = (dir_a & lat_a) | (~dir_a & s2_a);
      ADDR_DIR_A:  bus_rdata = dir_a;
      ADDR_DATA_B: bus_rdata = (dir_b & lat_b) | (~dir_b & s2_b);
      ADDR_DIR_B:  bus_rdata = dir_b;
      ADDR_DRV:    bus_rdata = drv_q;
      ADDR_PULL:   bus_rdata = pull_q;
      ADDR_LVL:    bus_rdata = {5'b0, lvl_q};
      default:     bus_rdata = 8'h00;
    endcase
  end

  // R8
  pu_off_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_a & oe_a) == 8'h00) && ((pu_b & oe_b) == 8'h00));

  // R10
  lvl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_LVL) |-> (bus_rdata[7:3] == 5'b0));

  // R6
  dir_wr_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == ADDR_DIR_A || bus_addr == ADDR_DIR_B))
      |=> ($stable(dout_a) && $stable(dout_b)));

  // R5
  data_wr_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == ADDR_DATA_A || bus_addr == ADDR_DATA_B))
      |=> ($stable(oe_a) && $stable(oe_b)));

  // R9
  drv_ignores_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr == ADDR_DIR_A || bus_addr == ADDR_DIR_B))
      |=> ($stable(drv_a) && $stable(drv_b)));

endmodule

// File: tb/tb_gpio_dual_port_ctl.sv
`timescale 1ns/1ps
module tb_gpio_dual_port_ctl;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [7:0] pin_in_a = 0, pin_in_b = 0;
  logic [7:0] oe_a, oe_b, dout_a, dout_b, pu_a, pu_b, drv_a, drv_b, ttl_a, ttl_b;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_dual_port_ctl dut (.*);

  function automatic logic [7:0] ea(input logic [7:0] g);
    logic [7:0] r;
    r[0] = g[0]; r[1] = g[1]; r[2] = g[1];
    for (int i = 3; i < 8; i++) r[i] = g[2];
    return r;
  endfunction
  function automatic logic [7:0] eb(input logic [7:0] g);
    logic [7:0] r;
    r[0] = g[3]; r[1] = g[4]; r[2] = g[4]; r[3] = g[5];
    r[4] = g[6]; r[5] = g[6]; r[6] = g[7]; r[7] = g[7];
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    foreach (oe_a[i]) ;
    chk("R1 oe_a", oe_a, 0); chk("R1 oe_b", oe_b, 0);
    chk("R1 dout", dout_a | dout_b, 0);
    chk("R1 pu", pu_a | pu_b, 0); chk("R1 drv", drv_a | drv_b, 0);
    chk("R1 ttl", ttl_a | ttl_b, 0);
    rd(8'h01, d); chk("R1 dirA", d, 0);
    rd(8'h03, d); chk("R1 dirB", d, 0);
    rd(8'h15, d); chk("R1 drv reg", d, 0);
    rd(8'h16, d); chk("R1 pull reg", d, 0);
    rd(8'h17, d); chk("R1 lvl reg", d, 0);
  endtask

  task automatic t_dir_read();
    logic [7:0] d;
    pin_in_a = 8'hC3; pin_in_b = 8'h5A;
    wr(8'h00, 8'h96); wr(8'h01, 8'hF0);
    wr(8'h02, 8'h3C); wr(8'h03, 8'h0F);
    repeat (2) @(negedge clk);
    chk("R2 oe_a", oe_a, 8'hF0); chk("R2 dout_a", dout_a, 8'h96);
    chk("R2 oe_b", oe_b, 8'h0F); chk("R2 dout_b", dout_b, 8'h3C);
    rd(8'h00, d); chk("R3 readA mix", d, (8'hF0 & 8'h96) | (8'h0F & 8'hC3));
    rd(8'h02, d); chk("R3 readB mix", d, (8'h0F & 8'h3C) | (8'hF0 & 8'h5A));
  endtask

  task automatic t_sync();
    logic [7:0] d;
    wr(8'h01, 8'h00);
    pin_in_a = 8'h11;
    repeat (3) @(negedge clk);
    pin_in_a = 8'hEE;
    @(negedge clk);
    rd(8'h00, d); chk("R4 one edge old", d, 8'h11);
    @(negedge clk);
    rd(8'h00, d); chk("R4 two edges new", d, 8'hEE);
  endtask

  task automatic t_input_write();
    logic [7:0] d;
    wr(8'h03, 8'h00);
    wr(8'h02, 8'hA5);
    chk("R5 oe_b stays 0", oe_b, 0);
    chk("R5 latch updated", dout_b, 8'hA5);
    wr(8'h03, 8'hFF);
    chk("R6 latch kept over dir write", dout_b, 8'hA5);
    rd(8'h02, d); chk("R5 drives stored value", d, 8'hA5);
  endtask

  task automatic t_pull();
    for (int b = 0; b < 8; b++) begin
      wr(8'h01, 8'h00); wr(8'h03, 8'h00);
      wr(8'h16, 8'h01 << b);
      chk($sformatf("R7 pu_a bit%0d", b), pu_a, ea(8'h01 << b));
      chk($sformatf("R7 pu_b bit%0d", b), pu_b, eb(8'h01 << b));
    end
    wr(8'h16, 8'hFF);
    wr(8'h01, 8'h0A); wr(8'h03, 8'hC1);
    chk("R8 pu_a masked", pu_a, 8'hF5);
    chk("R8 pu_b masked", pu_b, 8'h3E);
  endtask

  task automatic t_drive();
    logic [7:0] d;
    wr(8'h01, 8'h00); wr(8'h03, 8'hFF);
    for (int b = 0; b < 8; b++) begin
      wr(8'h15, 8'h80 >> b);
      chk($sformatf("R9 drv_a bit%0d", 7 - b), drv_a, ea(8'h80 >> b));
      chk($sformatf("R9 drv_b bit%0d", 7 - b), drv_b, eb(8'h80 >> b));
    end
    wr(8'h15, 8'h6D);
    rd(8'h15, d); chk("R12 drv readback", d, 8'h6D);
    rd(8'h16, d); chk("R12 pull readback", d, 8'hFF);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(8'h17, 8'hF9);
    chk("R10 ttl_a bit2 clear", ttl_a, 0);
    chk("R10 ttl_b bit0", ttl_b, 8'h80);
    rd(8'h17, d); chk("R10 unused read 0", d, 8'h01);
    wr(8'h17, 8'h02); chk("R10 ttl_b bit1", ttl_b, 8'h40);
    wr(8'h17, 8'h04);
    chk("R10 ttl_a bit2", ttl_a, 8'h0D); chk("R10 ttl_b none", ttl_b, 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [7:0] sa, sb, da, db, sp, sd;
    sa = oe_a; sb = oe_b; da = dout_a; db = dout_b; sp = pu_a; sd = drv_b;
    wr(8'h04, 8'hFF); wr(8'h14, 8'hFF); wr(8'h18, 8'hFF);
    rd(8'h04, d); chk("R11 read 0x04", d, 0);
    rd(8'h14, d); chk("R11 read 0x14", d, 0);
    rd(8'hFF, d); chk("R11 read 0xFF", d, 0);
    chk("R11 oe_a kept", oe_a, sa); chk("R11 oe_b kept", oe_b, sb);
    chk("R11 dout_a kept", dout_a, da); chk("R11 dout_b kept", dout_b, db);
    chk("R11 pu_a kept", pu_a, sp); chk("R11 drv_b kept", drv_b, sd);
    rd(8'h17, d); chk("R11 lvl kept", d, 8'h04);
    rd(8'h15, d); chk("R11 drv kept", d, 8'h6D);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dir_read();
    t_sync();
    t_input_write();
    t_pull();
    t_drive();
    t_level();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule